// File: doc/BRIEF.md
# Segmented LRU Way Selector

This block holds the replacement state of one set of an N-way set-associative cache. Each valid way belongs to one of two recency lists. Lines that have been touched once sit in the probationary list. Lines that have been hit again sit in the protected list. The protected list has a size limit, set by a parameter. When it is full, the oldest protected line is pushed back to the front of the probationary list rather than being dropped. This gives a line that used to be busy one more chance before it is evicted.

The cache controller reports one lookup result per cycle. It pulses `access_valid_i`, together with either a hit and the hit way, or a miss. On a miss, the way shown on `victim_way_o` is taken as the refilled way and becomes the newest probationary line. `fill_done_o` pulses in the next cycle to confirm that the install has happened. Every state update, including the new victim, is visible in the cycle after the access.

Top module: `slru_way_sel`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after its release, `victim_way_o` is 0 and `fill_done_o` is 0. All ways are invalid and probationary.
- R2: An access with `hit_i`=0 installs the way that `victim_way_o` showed in that cycle. The installed way becomes valid, at the most-recent end of the probationary list. In the next cycle `fill_done_o` is 1, and it is 0 after any other cycle.
- R3: When any way is invalid, `victim_way_o` is the lowest-numbered invalid way.
- R4: When all ways are valid and the probationary list is not empty, `victim_way_o` is the least-recent probationary way.
- R5: A hit on a valid probationary way moves it to the most-recent end of the protected list. It is then never the victim while the probationary list is not empty.
- R6: The protected list never holds more than `PROT_MAX` ways. A promotion into a full protected list moves the least-recent protected way to the most-recent end of the probationary list.
- R7: A hit on a protected way makes it the most-recent protected way. The order of the probationary list is unchanged.
- R8: When every way is valid and protected, `victim_way_o` is the least-recent protected way.
- R9: While `access_valid_i` is 0, `victim_way_o` holds its value. The values of `hit_i` and `hit_way_i` have no effect in that state.
- R10: A hit reported on an invalid way, or on an index of `NUM_WAYS` or more, changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_valid_i | input | 1 | A lookup result is presented this cycle |
| hit_i | input | 1 | 1: hit on `hit_way_i`; 0: miss, victim is refilled |
| hit_way_i | input | $clog2(NUM_WAYS) | Way that hit |
| victim_way_o | output | $clog2(NUM_WAYS) | Registered way to replace on the next miss |
| fill_done_o | output | 1 | One-cycle pulse after a miss, confirming the install |

## Verification
The checker enforces these rules on every clock:
- the protected-list size bound;
- the rule that ranks stay inside each list's population;
- invalid-first victim choice;
- the `fill_done_o` pulse after each miss and only then;
- a stable victim while no access is presented;
- the rule that a just-promoted way is not the victim.

Whether the victim is truly the least-recent line depends on the full access history. That can only be shown by the bench's scenarios. These include the following:
- the demotion chain through a full protected list;
- reordering inside the protected list;
- hits on invalid ways;
- the all-protected fallback in a second instance whose limit equals the way count.

// File: rtl/slru_pkg.sv
package slru_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_HIT_PROT,
    EV_HIT_PROB,
    EV_HIT_PROB_DEM,
    EV_FILL
  } slru_ev_e;
endpackage

// File: rtl/slru_event_dec.sv
module slru_event_dec
  import slru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int PROT_MAX = 2,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int RANK_W  = WAY_W,
  localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
  input  logic                             access_valid_i,
  input  logic                             hit_i,
  input  logic [WAY_W-1:0]                 hit_way_i,
  input  logic [WAY_W-1:0]                 victim_i,
  input  logic [NUM_WAYS-1:0]              valid_i,
  input  logic [NUM_WAYS-1:0]              prot_i,
  input  logic [NUM_WAYS-1:0][RANK_W-1:0]  rank_i,
  output slru_ev_e                         ev_o,
  output logic [WAY_W-1:0]                 tgt_way_o,
  output logic [RANK_W-1:0]                tgt_rank_o,
  output logic [WAY_W-1:0]                 dem_way_o
);
  logic [CNT_W-1:0] cnt_prot;
  logic             hit_ok;

  always_comb begin
    cnt_prot  = '0;
    dem_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (valid_i[w] && prot_i[w]) begin
        cnt_prot = cnt_prot + CNT_W'(1);
        // oldest protected slot when the list is at its limit
        if (int'(rank_i[w]) == PROT_MAX - 1) dem_way_o = WAY_W'(w);
      end
    end
  end

  always_comb begin
    hit_ok     = (int'(hit_way_i) < NUM_WAYS) && valid_i[hit_way_i];
    ev_o       = EV_NONE;
    tgt_way_o  = '0;
    tgt_rank_o = '0;
    if (access_valid_i) begin
      if (!hit_i) begin
        ev_o       = EV_FILL;
        tgt_way_o  = victim_i;
        tgt_rank_o = rank_i[victim_i];
      end else if (hit_ok) begin
        tgt_way_o  = hit_way_i;
        tgt_rank_o = rank_i[hit_way_i];
        if (prot_i[hit_way_i])              ev_o = EV_HIT_PROT;
        else if (int'(cnt_prot) >= PROT_MAX) ev_o = EV_HIT_PROB_DEM;
        else                                ev_o = EV_HIT_PROB;
      end
    end
  end
endmodule

// File: rtl/slru_way_cell.sv
module slru_way_cell
  import slru_pkg::*;
#(
  parameter int WAY_W  = 2,
  parameter int RANK_W = 2,
  parameter int IDX    = 0
) (
  input  slru_ev_e          ev_i,
  input  logic [WAY_W-1:0]  tgt_way_i,
  input  logic [RANK_W-1:0] tgt_rank_i,
  input  logic [WAY_W-1:0]  dem_way_i,
  input  logic              valid_i,
  input  logic              prot_i,
  input  logic [RANK_W-1:0] rank_i,
  output logic              valid_o,
  output logic              prot_o,
  output logic [RANK_W-1:0] rank_o
);
  logic is_tgt, is_dem, in_prot, in_prob;

  assign is_tgt  = (int'(tgt_way_i) == IDX);
  assign is_dem  = (int'(dem_way_i) == IDX);
  assign in_prot = valid_i && prot_i;
  assign in_prob = valid_i && !prot_i;

  always_comb begin
    valid_o = valid_i;
    prot_o  = prot_i;
    rank_o  = rank_i;
    unique case (ev_i)
      EV_HIT_PROT: begin
        if (is_tgt)                             rank_o = '0;
        else if (in_prot && rank_i < tgt_rank_i) rank_o = rank_i + RANK_W'(1);
      end
      EV_HIT_PROB: begin
        if (is_tgt) begin
          prot_o = 1'b1;
          rank_o = '0;
        end else if (in_prot) begin
          rank_o = rank_i + RANK_W'(1);
        end else if (in_prob && rank_i > tgt_rank_i) begin
          rank_o = rank_i - RANK_W'(1);
        end
      end
      EV_HIT_PROB_DEM: begin
        if (is_tgt) begin
          prot_o = 1'b1;
          rank_o = '0;
        end else if (is_dem && in_prot) begin
          prot_o = 1'b0;
          rank_o = '0;
        end else if (in_prot) begin
          rank_o = rank_i + RANK_W'(1);
        end else if (in_prob && rank_i < tgt_rank_i) begin
          // removal below and insertion on top cancel for older ways
          rank_o = rank_i + RANK_W'(1);
        end
      end
      EV_FILL: begin
        if (is_tgt) begin
          valid_o = 1'b1;
          prot_o  = 1'b0;
          rank_o  = '0;
        end else if (in_prob) begin
          rank_o = rank_i + RANK_W'(1);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slru_victim_pick.sv
module slru_victim_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int RANK_W  = WAY_W,
  localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
  input  logic [NUM_WAYS-1:0]             valid_i,
  input  logic [NUM_WAYS-1:0]             prot_i,
  input  logic [NUM_WAYS-1:0][RANK_W-1:0] rank_i,
  output logic [WAY_W-1:0]                victim_o
);
  logic [CNT_W-1:0] cnt_prob, cnt_prot;
  logic [WAY_W-1:0] inv_way, prob_lru, prot_lru;
  logic             any_inv;

  always_comb begin
    cnt_prob = '0;
    cnt_prot = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (valid_i[w] && !prot_i[w]) cnt_prob = cnt_prob + CNT_W'(1);
      if (valid_i[w] &&  prot_i[w]) cnt_prot = cnt_prot + CNT_W'(1);
    end
  end

  always_comb begin
    any_inv = 1'b0;
    inv_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        any_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    prob_lru = '0;
    prot_lru = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (valid_i[w] && !prot_i[w] && int'(rank_i[w]) == int'(cnt_prob) - 1)
        prob_lru = WAY_W'(w);
      if (valid_i[w] && prot_i[w] && int'(rank_i[w]) == int'(cnt_prot) - 1)
        prot_lru = WAY_W'(w);
    end
  end

  always_comb begin
    if (any_inv)             victim_o = inv_way;
    else if (cnt_prob != '0) victim_o = prob_lru;
    else                     victim_o = prot_lru;
  end
endmodule

// File: rtl/slru_way_sel.sv
module slru_way_sel
  import slru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int PROT_MAX = 2,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int RANK_W  = WAY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             access_valid_i,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  output logic [WAY_W-1:0] victim_way_o,
  output logic             fill_done_o
);
  logic [NUM_WAYS-1:0]             valid_q, valid_d;
  logic [NUM_WAYS-1:0]             prot_q, prot_d;
  logic [NUM_WAYS-1:0][RANK_W-1:0] rank_q, rank_d;
  logic [WAY_W-1:0]                victim_q, victim_d;
  logic                            fill_q;

  slru_ev_e          ev;
  logic [WAY_W-1:0]  tgt_way, dem_way;
  logic [RANK_W-1:0] tgt_rank;

  slru_event_dec #(
    .NUM_WAYS(NUM_WAYS),
    .PROT_MAX(PROT_MAX)
  ) u_dec (
    .access_valid_i(access_valid_i),
    .hit_i         (hit_i),
    .hit_way_i     (hit_way_i),
    .victim_i      (victim_q),
    .valid_i       (valid_q),
    .prot_i        (prot_q),
    .rank_i        (rank_q),
    .ev_o          (ev),
    .tgt_way_o     (tgt_way),
    .tgt_rank_o    (tgt_rank),
    .dem_way_o     (dem_way)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    slru_way_cell #(
      .WAY_W (WAY_W),
      .RANK_W(RANK_W),
      .IDX   (w)
    ) u_cell (
      .ev_i      (ev),
      .tgt_way_i (tgt_way),
      .tgt_rank_i(tgt_rank),
      .dem_way_i (dem_way),
      .valid_i   (valid_q[w]),
      .prot_i    (prot_q[w]),
      .rank_i    (rank_q[w]),
      .valid_o   (valid_d[w]),
      .prot_o    (prot_d[w]),
      .rank_o    (rank_d[w])
    );
  end

  // victim is computed from next state so the output is registered
  slru_victim_pick #(
    .NUM_WAYS(NUM_WAYS)
  ) u_pick (
    .valid_i (valid_d),
    .prot_i  (prot_d),
    .rank_i  (rank_d),
    .victim_o(victim_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      prot_q   <= '0;
      rank_q   <= '0;
      victim_q <= '0;
      fill_q   <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      prot_q   <= prot_d;
      rank_q   <= rank_d;
      victim_q <= victim_d;
      fill_q   <= (ev == EV_FILL);
    end
  end

  assign victim_way_o = victim_q;
  assign fill_done_o  = fill_q;
endmodule

// File: rtl/slru_way_sel_chk.sv
module slru_way_sel_chk #(
  parameter int NUM_WAYS = 4,
  parameter int PROT_MAX = 2,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int RANK_W  = WAY_W
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             access_valid_i,
  input logic                             hit_i,
  input logic [WAY_W-1:0]                 hit_way_i,
  input logic [WAY_W-1:0]                 victim_way_o,
  input logic                             fill_done_o,
  input logic [NUM_WAYS-1:0]              valid_q,
  input logic [NUM_WAYS-1:0]              prot_q,
  input logic [NUM_WAYS-1:0][RANK_W-1:0]  rank_q
);
  int n_prot, n_prob;
  assign n_prot = $countones(valid_q & prot_q);
  assign n_prob = $countones(valid_q & ~prot_q);

  p_fill_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_valid_i && !hit_i) |=> fill_done_o);

  p_fill_only_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(access_valid_i && !hit_i) |=> !fill_done_o);

  p_invalid_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q != '1) |-> !valid_q[victim_way_o]);

  p_promoted_not_victim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PROT_MAX < NUM_WAYS && access_valid_i && hit_i &&
     int'(hit_way_i) < NUM_WAYS && valid_q[hit_way_i])
    |=> (victim_way_o != $past(hit_way_i)));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_prot <= PROT_MAX);

  p_idle_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_valid_i |=> $stable(victim_way_o));

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rank
    p_rank_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q[w] |-> (int'(rank_q[w]) < (prot_q[w] ? n_prot : n_prob)));
  end
endmodule

bind slru_way_sel slru_way_sel_chk #(
  .NUM_WAYS(NUM_WAYS),
  .PROT_MAX(PROT_MAX)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .access_valid_i(access_valid_i),
  .hit_i         (hit_i),
  .hit_way_i     (hit_way_i),
  .victim_way_o  (victim_way_o),
  .fill_done_o   (fill_done_o),
  .valid_q       (valid_q),
  .prot_q        (prot_q),
  .rank_q        (rank_q)
);

// File: tb/slru_way_sel_bench.sv
`timescale 1ns/1ps
module slru_way_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       av = 1'b0;
  logic       hit = 1'b0;
  logic [1:0] way = 2'd0;
  logic [1:0] vict, vict_f;
  logic       fill, fill_f;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  slru_way_sel #(.NUM_WAYS(4), .PROT_MAX(2)) u_slru_way_sel (
    .clk_i(clk), .rst_ni(rst_n), .access_valid_i(av), .hit_i(hit),
    .hit_way_i(way), .victim_way_o(vict), .fill_done_o(fill)
  );

  slru_way_sel #(.NUM_WAYS(4), .PROT_MAX(4)) u_slru_way_sel_full (
    .clk_i(clk), .rst_ni(rst_n), .access_valid_i(av), .hit_i(hit),
    .hit_way_i(way), .victim_way_o(vict_f), .fill_done_o(fill_f)
  );

  // {access_valid, hit, hit_way[1:0], exp_victim[1:0], exp_fill, pad}
  localparam logic [7:0] VEC [18] = '{
    8'b1_0_00_01_1_0,  // miss -> way0 filled
    8'b1_0_00_10_1_0,
    8'b1_0_00_11_1_0,
    8'b1_0_00_00_1_0,  // all valid, prob LRU is 0
    8'b0_0_00_00_0_0,  // idle
    8'b1_0_00_01_1_0,  // refill 0
    8'b1_1_01_10_0_0,  // promote 1
    8'b1_1_10_11_0_0,  // promote 2, protected full
    8'b1_1_00_11_0_0,  // promote 0, demote 1
    8'b1_0_00_01_1_0,  // refill 3
    8'b1_1_10_01_0_0,  // reorder protected
    8'b1_1_01_11_0_0,  // promote 1, demote 0
    8'b1_1_11_00_0_0,  // promote 3, demote 2
    8'b1_0_00_10_1_0,  // refill 0
    8'b1_1_01_10_0_0,  // reorder protected
    8'b0_1_11_10_0_0,  // idle with hit fields set
    8'b1_1_00_10_0_0,  // promote 0, demote 3
    8'b1_0_00_11_1_0   // refill 2
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2:           return "R3";
      3, 5, 9, 13, 17:   return "R4";
      4, 15:             return "R9";
      6, 7:              return "R5";
      10, 14:            return "R7";
      default:           return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(input logic a, input logic h, input logic [1:0] w);
    av = a; hit = h; way = w;
    @(negedge clk);
    av = 1'b0; hit = 1'b0; way = 2'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 victim in reset", int'(vict), 0);
    chk("R1 fill in reset", int'(fill), 0);
    chk("R1 full victim in reset", int'(vict_f), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 victim after release", int'(vict), 0);
    chk("R1 fill after release", int'(fill), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 victim after reset", int'(vict), 0);
    chk("R1 fill after reset", int'(fill), 0);

    for (int i = 0; i < 18; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5:4]);
      chk(tag_of(i), int'(vict), int'(VEC[i][3:2]));
      chk("R2 fill_done", int'(fill), int'(VEC[i][1]));
    end

    // R9: long idle hold with changing hit fields
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b1, 2'(k));
      chk("R9 idle hold", int'(vict), 3);
    end

    // R10: hit on invalid way changes nothing
    do_reset();
    step(1'b1, 1'b0, 2'd0);
    step(1'b1, 1'b0, 2'd0);
    chk("R3 second invalid", int'(vict), 2);
    step(1'b1, 1'b1, 2'd2);
    chk("R10 hit on invalid way", int'(vict), 2);
    chk("R10 no fill on hit", int'(fill), 0);
    step(1'b1, 1'b0, 2'd0);
    chk("R2 fill after ignored hit", int'(vict), 3);
    chk("R2 fill_done after miss", int'(fill), 1);

    // R8: all-protected fallback on the instance with PROT_MAX == NUM_WAYS
    do_reset();
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 2'd0);
      chk("R3 full fill", int'(vict_f), (k + 1) % 4);
    end
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b1, 2'(k));
      chk("R8 full promote", int'(vict_f), (k + 1) % 4);
    end
    step(1'b1, 1'b0, 2'd0);
    chk("R8 refill from protected", int'(vict_f), 0);
    chk("R2 full fill_done", int'(fill_f), 1);
    step(1'b1, 1'b1, 2'd0);
    chk("R8 protected LRU again", int'(vict_f), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule